// File: doc/BRIEF.md
# Register-Mapped Multiply and Multiply-Accumulate Unit

This peripheral sits on a simple synchronous register port (word address, write enable, 16-bit write data, 16-bit combinational read data) and does arithmetic for a processor that has no multiplier of its own. It has two independent engines. The first is a 16x16 engine with a running accumulator. Software picks one of four first-operand registers to store the first operand, and the choice of register also sets the mode: plain unsigned, plain signed, unsigned accumulate or signed accumulate. Writing the second operand then starts the operation. The second engine is a 32x32 multiplier. Each of its 32-bit operands is written as two 16-bit halves, and the 64-bit product is read back as four words.

All results are registered, so the value is visible on the clock cycle after the triggering write. Reads are combinational from the registered state. The 16-bit engine gives a low result word, a high result word and a sum-extension word. The sum-extension word carries sign information that depends on the mode. Writing the low-result register seeds the accumulator, so a chain of accumulates can start from any value.

Top module: `mmac_periph`

## Requirements
- R1: After reset, all results, accumulators and operands read as zero and the 16-bit engine is in plain unsigned mode.
- R2: A write to a first-operand register (addresses 0..3, mode = address bits [1:0]: 0 plain unsigned, 1 plain signed, 2 unsigned accumulate, 3 signed accumulate) stores the operand and the mode and leaves the readable result unchanged.
- R3: A write to the second operand (address 4) in a plain mode loads the product of the stored first operand and the written value into the result (address 5 low word, address 6 high word) and clears both accumulators.
- R4: A write to the second operand in an accumulate mode adds the product to the accumulator, and the result then equals the new accumulator value.
- R5: Signed modes treat both 16-bit operands as two's complement values.
- R6: The sum-extension word (address 7) reads 0 in both unsigned modes. In plain signed mode it reads 0xFFFF when the signed result is negative, and 0 otherwise. In signed accumulate mode it reads 0xFFFF when the signed accumulator is negative, and 0 otherwise.
- R7: A write to address 5 loads the value into the accumulators. In the current mode's signedness, the result takes the value zero-extended (unsigned mode) or sign-extended (signed mode). The accumulator of the other signedness takes the other extension.
- R8: For the 32x32 engine, a low first-operand write (address 8 unsigned, address 9 signed) sets the first operand to the zero-extended value and selects the 64-bit mode. Address 10 replaces the upper half of the first operand.
- R9: Address 11 sets the second operand to the zero-extended value and does not change the result. Address 12 replaces the upper half of the second operand and triggers the 64-bit multiply. The product reads as words at addresses 16 (least significant) to 19.
- R10: A result is readable on the cycle after its triggering write.
- R11: Writes to read-only addresses (6, 7, 16..19) change nothing.
- R12: Reads of operand addresses (0..4, 8..12) and of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Word address |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr and registered state |

## Verification
The assertions assume that at most one register is written per cycle, and that the address is stable and fully defined whenever the write enable is high. The bench drives every write for exactly one clock, with address and data set up at the falling edge, and deasserts the enable before the next access. Reads only change the address and never assert the enable, so no read can be mistaken for a trigger or a preload.

// File: rtl/mmac_pkg.sv
`timescale 1ns/1ps
package mmac_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 5;
    localparam int GUARD_W = 8;

    // 16-bit engine modes; bit 0 = signed, bit 1 = accumulate
    typedef enum logic [1:0] {
        MD_UMUL = 2'd0,
        MD_SMUL = 2'd1,
        MD_UMAC = 2'd2,
        MD_SMAC = 2'd3
    } mac_mode_e;

    localparam logic [ADDR_W-1:0] A_OP1_UMUL  = 5'd0;
    localparam logic [ADDR_W-1:0] A_OP1_SMUL  = 5'd1;
    localparam logic [ADDR_W-1:0] A_OP1_UMAC  = 5'd2;
    localparam logic [ADDR_W-1:0] A_OP1_SMAC  = 5'd3;
    localparam logic [ADDR_W-1:0] A_OP2       = 5'd4;
    localparam logic [ADDR_W-1:0] A_RES_LO    = 5'd5;
    localparam logic [ADDR_W-1:0] A_RES_HI    = 5'd6;
    localparam logic [ADDR_W-1:0] A_SUMEXT    = 5'd7;
    localparam logic [ADDR_W-1:0] A_W_OP1_LOU = 5'd8;
    localparam logic [ADDR_W-1:0] A_W_OP1_LOS = 5'd9;
    localparam logic [ADDR_W-1:0] A_W_OP1_HI  = 5'd10;
    localparam logic [ADDR_W-1:0] A_W_OP2_LO  = 5'd11;
    localparam logic [ADDR_W-1:0] A_W_OP2_HI  = 5'd12;
    localparam logic [ADDR_W-1:0] A_W_RES0    = 5'd16;

    typedef struct packed {
        logic      op1;
        mac_mode_e op1_mode;
        logic      op2;
        logic      preload;
    } st16_t;

    typedef struct packed {
        logic op1_lo;
        logic sel_signed;
        logic op1_hi;
        logic op2_lo;
        logic op2_hi;
    } st32_t;

    function automatic logic mode_signed(input mac_mode_e m);
        return m[0];
    endfunction

    function automatic logic mode_acc(input mac_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/mmac_wdec.sv
`timescale 1ns/1ps
module mmac_wdec
    import mmac_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          we,
    input  logic [AW-1:0] addr,
    output st16_t         st16,
    output st32_t         st32
);

    always_comb begin
        st16 = '0;
        st32 = '0;
        st16.op1_mode = mac_mode_e'(addr[1:0]);
        if (we) begin
            case (addr)
                A_OP1_UMUL, A_OP1_SMUL,
                A_OP1_UMAC, A_OP1_SMAC: st16.op1    = 1'b1;
                A_OP2:                  st16.op2    = 1'b1;
                A_RES_LO:               st16.preload = 1'b1;
                A_W_OP1_LOU: begin
                    st32.op1_lo     = 1'b1;
                    st32.sel_signed = 1'b0;
                end
                A_W_OP1_LOS: begin
                    st32.op1_lo     = 1'b1;
                    st32.sel_signed = 1'b1;
                end
                A_W_OP1_HI:             st32.op1_hi = 1'b1;
                A_W_OP2_LO:             st32.op2_lo = 1'b1;
                A_W_OP2_HI:             st32.op2_hi = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mmac_mul16.sv
`timescale 1ns/1ps
module mmac_mul16
    import mmac_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int GW = GUARD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  st16_t            st,
    input  logic [DW-1:0]    wdata,
    output mac_mode_e        mode,
    output logic [2*DW-1:0]  view,
    output logic             ext_fill
);

    localparam int PW = 2 * DW;       // product width
    localparam int SW = PW + GW;      // signed accumulator width

    logic [DW-1:0] op1_q;
    mac_mode_e     mode_q;
    logic [PW-1:0] acc_u_q, res_u_q;
    logic [SW-1:0] acc_s_q;
    logic [PW:0]   res_s_q;          // {sign, low product bits}

    logic          sgn;
    logic [SW-1:0] a_ext, b_ext, prod_w, acc_s_sum, pre_s;
    logic [PW-1:0] prod_u, acc_u_sum, pre_u;

    always_comb begin
        sgn       = mode_signed(mode_q);
        a_ext     = sgn ? {{(SW-DW){op1_q[DW-1]}}, op1_q} : {{(SW-DW){1'b0}}, op1_q};
        b_ext     = sgn ? {{(SW-DW){wdata[DW-1]}}, wdata} : {{(SW-DW){1'b0}}, wdata};
        prod_w    = a_ext * b_ext;
        prod_u    = prod_w[PW-1:0];
        acc_u_sum = acc_u_q + prod_u;
        acc_s_sum = acc_s_q + prod_w;
        pre_u     = {{(PW-DW){1'b0}}, wdata};
        pre_s     = {{(SW-DW){wdata[DW-1]}}, wdata};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op1_q   <= '0;
            mode_q  <= MD_UMUL;
            acc_u_q <= '0;
            acc_s_q <= '0;
            res_u_q <= '0;
            res_s_q <= '0;
        end else begin
            if (st.op1) begin
                op1_q  <= wdata;
                mode_q <= st.op1_mode;
            end
            if (st.op2) begin
                if (mode_acc(mode_q)) begin
                    acc_u_q <= acc_u_sum;
                    acc_s_q <= acc_s_sum;
                    res_u_q <= acc_u_sum;
                    res_s_q <= {acc_s_sum[SW-1], acc_s_sum[PW-1:0]};
                end else begin
                    acc_u_q <= '0;
                    acc_s_q <= '0;
                    res_u_q <= prod_u;
                    res_s_q <= {prod_w[SW-1], prod_w[PW-1:0]};
                end
            end
            if (st.preload) begin
                acc_u_q <= pre_u;
                acc_s_q <= pre_s;
                if (sgn) res_s_q <= {pre_s[SW-1], pre_s[PW-1:0]};
                else     res_u_q <= pre_u;
            end
        end
    end

    always_comb begin
        mode     = mode_q;
        view     = mode_signed(mode_q) ? res_s_q[PW-1:0] : res_u_q;
        case (mode_q)
            MD_SMUL: ext_fill = res_s_q[PW];
            MD_SMAC: ext_fill = acc_s_q[SW-1];
            default: ext_fill = 1'b0;
        endcase
    end

    // R2: storing a first operand leaves the result alone
    p_op1_keeps_result_r2: assert property (@(posedge clk) disable iff (rst)
        st.op1 |=> ($stable(res_u_q) && $stable(res_s_q)));

    // R3: plain multiply empties both accumulators
    p_mul_clears_acc_r3: assert property (@(posedge clk) disable iff (rst)
        (st.op2 && !mode_acc(mode_q)) |=> (acc_u_q == '0 && acc_s_q == '0));

    // R4: accumulate result mirrors the accumulator
    p_mac_result_tracks_acc_r4: assert property (@(posedge clk) disable iff (rst)
        (st.op2 && mode_acc(mode_q)) |=> (res_u_q == acc_u_q && res_s_q[PW-1:0] == acc_s_q[PW-1:0]));

    // R5: two negative signed operands give a non-negative product
    p_neg_by_neg_r5: assert property (@(posedge clk) disable iff (rst)
        (st.op2 && mode_q == MD_SMUL && op1_q[DW-1] && wdata[DW-1]) |=> !res_s_q[PW]);

    // R7: unsigned preload zero-extends into the result
    p_preload_unsigned_r7: assert property (@(posedge clk) disable iff (rst)
        (st.preload && !mode_signed(mode_q)) |=> (res_u_q == {{(PW-DW){1'b0}}, $past(wdata)}));

endmodule

// File: rtl/mmac_mul32.sv
`timescale 1ns/1ps
module mmac_mul32
    import mmac_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  st32_t           st,
    input  logic [DW-1:0]   wdata,
    output logic [4*DW-1:0] result
);

    localparam int OW = 2 * DW;   // operand width
    localparam int RW = 2 * OW;   // product width

    logic [OW-1:0] op1_q, op2_q, op2_new;
    logic          sgn_q;
    logic [RW-1:0] res_q, a_ext, b_ext, prod;

    always_comb begin
        op2_new = {wdata, op2_q[DW-1:0]};
        a_ext   = sgn_q ? {{(RW-OW){op1_q[OW-1]}}, op1_q}     : {{(RW-OW){1'b0}}, op1_q};
        b_ext   = sgn_q ? {{(RW-OW){op2_new[OW-1]}}, op2_new} : {{(RW-OW){1'b0}}, op2_new};
        prod    = a_ext * b_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op1_q <= '0;
            op2_q <= '0;
            sgn_q <= 1'b0;
            res_q <= '0;
        end else begin
            if (st.op1_lo) begin
                op1_q <= {{(OW-DW){1'b0}}, wdata};
                sgn_q <= st.sel_signed;
            end
            if (st.op1_hi) op1_q[OW-1:DW] <= wdata;
            if (st.op2_lo) op2_q <= {{(OW-DW){1'b0}}, wdata};
            if (st.op2_hi) begin
                op2_q <= op2_new;
                res_q <= prod;
            end
        end
    end

    assign result = res_q;

    // R8: a low first-operand write clears the upper half
    p_op1_low_clears_high_r8: assert property (@(posedge clk) disable iff (rst)
        st.op1_lo |=> (op1_q[OW-1:DW] == '0));

    // R9: only the upper second-operand write starts the multiply
    p_op2_low_no_trigger_r9: assert property (@(posedge clk) disable iff (rst)
        (st.op2_lo || st.op1_lo || st.op1_hi) |=> $stable(res_q));

endmodule

// File: rtl/mmac_periph.sv
`timescale 1ns/1ps
module mmac_periph
    import mmac_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = ADDR_W,
    parameter int GW = GUARD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata
);

    localparam int NWRES = 4;

    st16_t             st16;
    st32_t             st32;
    mac_mode_e         mode;
    logic [2*DW-1:0]   view;
    logic              ext_fill;
    logic [4*DW-1:0]   wide_res;

    mmac_wdec #(.AW(AW)) wdec_i (
        .we   (bus_we),
        .addr (bus_addr),
        .st16 (st16),
        .st32 (st32)
    );

    mmac_mul16 #(.DW(DW), .GW(GW)) mul16_i (
        .clk      (clk),
        .rst      (rst),
        .st       (st16),
        .wdata    (bus_wdata),
        .mode     (mode),
        .view     (view),
        .ext_fill (ext_fill)
    );

    mmac_mul32 #(.DW(DW)) mul32_i (
        .clk    (clk),
        .rst    (rst),
        .st     (st32),
        .wdata  (bus_wdata),
        .result (wide_res)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RES_LO:  bus_rdata = view[DW-1:0];
            A_RES_HI:  bus_rdata = view[2*DW-1:DW];
            A_SUMEXT:  bus_rdata = {DW{ext_fill}};
            default: begin
                for (int i = 0; i < NWRES; i++) begin
                    if (bus_addr == A_W_RES0 + AW'(i))
                        bus_rdata = wide_res[i*DW +: DW];
                end
            end
        endcase
    end

    // R6: unsigned modes never report a sign in the extension word
    p_sumext_unsigned_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_SUMEXT && !mode_signed(mode)) |-> (bus_rdata == '0));

    // R11: writes to read-only words leave every result untouched
    p_readonly_write_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == A_RES_HI || bus_addr == A_SUMEXT || bus_addr[AW-1:2] == A_W_RES0[AW-1:2]))
        |=> ($stable(view) && $stable(ext_fill) && $stable(wide_res)));

    // R12: operand addresses read back as zero
    p_operand_reads_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_addr <= A_OP2 || (bus_addr >= A_W_OP1_LOU && bus_addr <= A_W_OP2_HI)) |-> (bus_rdata == '0));

endmodule

// File: tb/mmac_periph_tb_top.sv
`timescale 1ns/1ps
module mmac_periph_tb_top;
    import mmac_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    mmac_periph dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_we    (we),
        .bus_wdata (wdata),
        .bus_rdata (rdata)
    );

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
        addr = a; we = 1'b0;
        #0.5;
        n_chk++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0d: actual %h expected %h", req, a, rdata, exp);
        end
        @(negedge clk);
    endtask

    task automatic wide_chk(input string req, input logic [63:0] exp);
        for (int i = 0; i < 4; i++)
            rd_chk(req, A_W_RES0 + 5'(i), exp[i*16 +: 16]);
    endtask

    task automatic t_reset;
        rd_chk("R1", A_RES_LO, 16'h0000);
        rd_chk("R1", A_RES_HI, 16'h0000);
        rd_chk("R1", A_SUMEXT, 16'h0000);
        wide_chk("R1", 64'h0);
    endtask

    task automatic t_umul;
        logic [31:0] p;
        p = 32'hFFFF * 32'hFFFF;
        wr(A_OP1_UMUL, 16'hFFFF);
        wr(A_OP2, 16'hFFFF);
        rd_chk("R10", A_RES_LO, p[15:0]);   // first read, cycle after the write
        rd_chk("R3", A_RES_HI, p[31:16]);
        rd_chk("R6", A_SUMEXT, 16'h0000);
    endtask

    task automatic t_op1_hold;
        wr(A_OP1_UMUL, 16'h0003);
        rd_chk("R2", A_RES_LO, 16'h0001);
        rd_chk("R2", A_RES_HI, 16'hFFFE);
        wr(A_OP2, 16'h0005);
        rd_chk("R3", A_RES_LO, 16'h000F);
        rd_chk("R3", A_RES_HI, 16'h0000);
    endtask

    task automatic t_smul;
        logic [31:0] p;
        p = 32'(-32'sd1 * 32'sd3);
        wr(A_OP1_SMUL, 16'hFFFF);
        wr(A_OP2, 16'h0003);
        rd_chk("R5", A_RES_LO, p[15:0]);
        rd_chk("R5", A_RES_HI, p[31:16]);
        rd_chk("R6", A_SUMEXT, 16'hFFFF);
        p = 32'(-32'sd2 * -32'sd3);
        wr(A_OP1_SMUL, 16'hFFFE);
        wr(A_OP2, 16'hFFFD);
        rd_chk("R5", A_RES_LO, p[15:0]);
        rd_chk("R5", A_RES_HI, p[31:16]);
        rd_chk("R6", A_SUMEXT, 16'h0000);
    endtask

    task automatic t_umac;
        logic [31:0] acc;
        acc = 32'h8000 * 32'h4;
        wr(A_OP1_UMAC, 16'h8000);
        wr(A_OP2, 16'h0004);
        rd_chk("R4", A_RES_LO, acc[15:0]);
        rd_chk("R4", A_RES_HI, acc[31:16]);
        acc = acc + 32'h8000 * 32'h4;
        wr(A_OP2, 16'h0004);
        rd_chk("R4", A_RES_HI, acc[31:16]);
        acc = acc + 32'h8000 * 32'hFFFF;
        wr(A_OP2, 16'hFFFF);
        rd_chk("R4", A_RES_LO, acc[15:0]);
        rd_chk("R4", A_RES_HI, acc[31:16]);
        rd_chk("R6", A_SUMEXT, 16'h0000);
    endtask

    task automatic t_mul_clears;
        wr(A_OP1_UMUL, 16'h0002);
        wr(A_OP2, 16'h0003);
        wr(A_OP1_UMAC, 16'h0001);
        wr(A_OP2, 16'h0001);
        rd_chk("R3", A_RES_LO, 16'h0001);
        rd_chk("R3", A_RES_HI, 16'h0000);
    endtask

    task automatic t_smac;
        logic [31:0] acc;
        wr(A_OP1_SMAC, 16'hFFFF);
        wr(A_RES_LO, 16'h0002);
        rd_chk("R7", A_RES_LO, 16'h0002);
        rd_chk("R7", A_RES_HI, 16'h0000);
        acc = 32'(32'sd2 + (-32'sd1 * 32'sd5));
        wr(A_OP2, 16'h0005);
        rd_chk("R4", A_RES_LO, acc[15:0]);
        rd_chk("R4", A_RES_HI, acc[31:16]);
        rd_chk("R6", A_SUMEXT, 16'hFFFF);
        acc = acc + 32'(-32'sd5);
        wr(A_OP2, 16'h0005);
        rd_chk("R4", A_RES_LO, acc[15:0]);
        acc = acc + 32'd16;
        wr(A_OP1_SMAC, 16'h0010);
        wr(A_OP2, 16'h0001);
        rd_chk("R4", A_RES_LO, acc[15:0]);
        rd_chk("R6", A_SUMEXT, 16'h0000);
    endtask

    task automatic t_preload;
        wr(A_OP1_UMUL, 16'h0000);
        wr(A_RES_LO, 16'h8001);
        rd_chk("R7", A_RES_LO, 16'h8001);
        rd_chk("R7", A_RES_HI, 16'h0000);
        wr(A_OP1_SMUL, 16'h0000);
        wr(A_RES_LO, 16'h8001);
        rd_chk("R7", A_RES_LO, 16'h8001);
        rd_chk("R7", A_RES_HI, 16'hFFFF);
        rd_chk("R6", A_SUMEXT, 16'hFFFF);
        // unsigned accumulator got the zero-extended value
        wr(A_OP1_UMAC, 16'h0001);
        wr(A_OP2, 16'h0001);
        rd_chk("R7", A_RES_LO, 16'h8002);
        rd_chk("R7", A_RES_HI, 16'h0000);
    endtask

    task automatic t_wide;
        logic [63:0] p;
        wr(A_W_OP1_LOU, 16'hFFFF);
        wr(A_W_OP1_HI, 16'hFFFF);
        wr(A_W_OP2_LO, 16'hFFFF);
        wide_chk("R9", 64'h0);
        p = 64'hFFFF_FFFF * 64'hFFFF_FFFF;
        wr(A_W_OP2_HI, 16'hFFFF);
        wide_chk("R9", p);
        wr(A_W_OP1_LOS, 16'hFFFF);
        wr(A_W_OP1_HI, 16'hFFFF);
        wr(A_W_OP2_LO, 16'h0002);
        wide_chk("R9", p);
        p = 64'(-64'sd1 * 64'sd2);
        wr(A_W_OP2_HI, 16'h0000);
        wide_chk("R9", p);
        p = 64'(64'sd3 * -64'sd1);
        wr(A_W_OP1_LOS, 16'h0003);
        wr(A_W_OP2_LO, 16'hFFFF);
        wr(A_W_OP2_HI, 16'hFFFF);
        wide_chk("R8", p);
        p = 64'd3 * 64'hFFFF_FFFF;
        wr(A_W_OP1_LOU, 16'h0003);
        wr(A_W_OP2_LO, 16'hFFFF);
        wr(A_W_OP2_HI, 16'hFFFF);
        wide_chk("R8", p);
    endtask

    task automatic t_readonly;
        logic [63:0] p;
        p = 64'd3 * 64'hFFFF_FFFF;
        wr(A_RES_HI, 16'h1234);
        wr(A_SUMEXT, 16'h5555);
        wr(A_W_RES0, 16'hAAAA);
        wr(A_W_RES0 + 5'd3, 16'h7777);
        rd_chk("R11", A_RES_LO, 16'h8002);
        rd_chk("R11", A_RES_HI, 16'h0000);
        rd_chk("R11", A_SUMEXT, 16'h0000);
        wide_chk("R11", p);
    endtask

    task automatic t_op_reads;
        for (int a = 0; a <= 4; a++) rd_chk("R12", 5'(a), 16'h0000);
        for (int a = 8; a <= 12; a++) rd_chk("R12", 5'(a), 16'h0000);
        rd_chk("R12", 5'd13, 16'h0000);
        rd_chk("R12", 5'd31, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_umul();
        t_op1_hold();
        t_smul();
        t_umac();
        t_mul_clears();
        t_smac();
        t_preload();
        t_wide();
        t_readonly();
        t_op_reads();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule